// File: doc/BRIEF.md
# Single-Cycle Integer Subset Core

The block is a small 32-bit processor core that completes one instruction per clock. It reads 32-bit instruction words from its own instruction store and executes five operations: register add, register subtract, add-immediate, word load and word store. Any other operation code or function code does nothing except advance the program counter. Execution uses a 32 x 32-bit register file with two read ports and one write port, an adder/subtractor, a 16-bit immediate sign extender, and a byte-addressed data store. Words in the data store are big-endian, so the most significant byte sits at the lowest byte address.

The core runs only while `run_i` is high. While `run_i` is low it holds its state. During that time a host can write instruction words and data bytes through the load ports. It can also read any register or any aligned data word through the probe ports. A word access whose effective address is not a multiple of 4 sets a sticky error flag and leaves registers and memory unchanged.

Top module: `rsub_core`

## Requirements
- R1: After reset, `pc_o` is 0, `err_o` is 0 and every register reads 0. Memory contents are not reset.
- R2: Register format, from bit 31 down, is opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. Opcode 0 with funct 32 writes rs+rt to rd. Opcode 0 with funct 34 writes rs-rt to rd. Both wrap modulo 2^32 and raise no trap. The add of r17 and r18 into r8 encodes as 0x02324020.
- R3: Immediate format is opcode[31:26], rs[25:21], rt[20:16] and imm[15:0]. Opcode 8 writes rs plus the sign-extended immediate to rt, wrapping modulo 2^32. A negative immediate therefore subtracts.
- R4: Opcode 35 loads into rt the word at rs + sign-extended imm. The byte at that address becomes bits 31:24 and the byte at address+3 becomes bits 7:0.
- R5: Opcode 43 stores rt to rs + sign-extended imm in the same big-endian byte order.
- R6: Register 0 always reads 0. A write that targets it has no effect.
- R7: A load or store whose effective address has bits 1:0 not equal to 0 sets `err_o`. `err_o` stays set until reset. That instruction changes neither the register file nor the data store.
- R8: An opcode outside {0, 8, 35, 43}, an opcode 0 instruction with funct outside {32, 34}, and an opcode 0 instruction with non-zero shamt all change no register and no memory.
- R9: On each rising edge with `run_i` high, the instruction at word index pc[7:2] executes and `pc_o` increases by 4. With `run_i` low, the PC, registers, data store and error flag hold.
- R10: The instruction load port writes a word at its word index. The data load port writes one byte while `run_i` is low. With `run_i` low, `reg_val_o` shows the register selected by `probe_reg_i`, and `mem_val_o` shows the big-endian word at `probe_addr_i` with bits 1:0 ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Execute one instruction per cycle when high |
| imem_we_i | input | 1 | Instruction word write strobe |
| imem_addr_i | input | 6 | Instruction word index |
| imem_data_i | input | 32 | Instruction word to write |
| dmem_we_i | input | 1 | Data byte write strobe (honoured while run_i low) |
| dmem_addr_i | input | 8 | Data byte address |
| dmem_data_i | input | 8 | Data byte to write |
| probe_reg_i | input | 5 | Register selected for observation |
| probe_addr_i | input | 8 | Byte address of data word to observe |
| reg_val_o | output | 32 | Value of selected register (valid while run_i low) |
| mem_val_o | output | 32 | Big-endian data word at probe_addr_i |
| pc_o | output | 32 | Program counter |
| err_o | output | 1 | Sticky misaligned-access flag |

## Verification
On every cycle, the assertions check how the program counter steps and holds, that the error flag stays set once raised and is set after a misaligned access, that a misaligned access produces no register or memory write, and that register 0 reads zero. Only the bench's scenarios can show whether the arithmetic results are correct. The bench sweeps the program across pairs of operand values that include zero, all ones and both signed extremes. That sweep is also how it shows the big-endian byte assembly of loads and stores, base-plus-negative-offset addressing, sign extension of immediates, and that unlisted codes leave state untouched.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_LDW  = 6'd35;
  localparam logic [5:0] OP_STW  = 6'd43;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;

  typedef struct packed {
    logic reg_we;
    logic dst_rd;
    logic use_imm;
    logic sub;
    logic mem_rd;
    logic mem_wr;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{default: 1'b0};
endpackage

// File: rtl/rsub_decode.sv
module rsub_decode
  import rsub_pkg::*;
(
  input  logic [31:0]     instr_i,
  output logic [RAW-1:0]  rs_o,
  output logic [RAW-1:0]  rt_o,
  output logic [RAW-1:0]  rd_o,
  output logic [XLEN-1:0] imm_o,
  output ctrl_t           ctrl_o
);
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [4:0]  shamt;
  logic [15:0] imm16;

  assign opc   = instr_i[31:26];
  assign rs_o  = instr_i[25:21];
  assign rt_o  = instr_i[20:16];
  assign rd_o  = instr_i[15:11];
  assign shamt = instr_i[10:6];
  assign fn    = instr_i[5:0];
  assign imm16 = instr_i[15:0];

  assign imm_o = {{(XLEN-16){imm16[15]}}, imm16};

  always_comb begin
    ctrl_o = CTRL_NOP;
    unique case (opc)
      OP_REG: begin
        if (shamt == '0 && (fn == FN_ADD || fn == FN_SUB)) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.sub    = (fn == FN_SUB);
        end
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_LDW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OP_STW: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
      end
      default: ctrl_o = CTRL_NOP;
    endcase
  end
endmodule

// File: rtl/rsub_regfile.sv
module rsub_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs[g] <= '0;
      else if (we_i && waddr_i == AW'(g))  regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[ra_i];
  assign rdata_b_o = regs[rb_i];

  p_zero_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == '0) |-> (rdata_a_o == '0));
  p_zero_reg_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_i == '0) |-> (rdata_b_o == '0));
endmodule

// File: rtl/rsub_dmem.sv
module rsub_dmem #(
  parameter int NBYTES = 256,
  localparam int AW    = $clog2(NBYTES),
  localparam int WAW   = AW - 2
) (
  input  logic           clk_i,
  input  logic           wr_en_i,
  input  logic [WAW-1:0] wr_idx_i,
  input  logic [31:0]    wr_data_i,
  input  logic           ld_en_i,
  input  logic [AW-1:0]  ld_addr_i,
  input  logic [7:0]     ld_byte_i,
  input  logic [WAW-1:0] rd_idx_i,
  output logic [31:0]    rd_data_o,
  input  logic [WAW-1:0] pr_idx_i,
  output logic [31:0]    pr_data_o
);
  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < 4; b++)
        mem[{wr_idx_i, 2'(b)}] <= wr_data_i[31-8*b -: 8];
    end else if (ld_en_i) begin
      mem[ld_addr_i] <= ld_byte_i;
    end
  end

  // lowest address carries the most significant byte
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign rd_data_o[31-8*b -: 8] = mem[{rd_idx_i, 2'(b)}];
    assign pr_data_o[31-8*b -: 8] = mem[{pr_idx_i, 2'(b)}];
  end
endmodule

// File: rtl/rsub_core.sv
module rsub_core
  import rsub_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_BYTES = 256,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_addr_i,
  input  logic [31:0]     imem_data_i,
  input  logic            dmem_we_i,
  input  logic [DAW-1:0]  dmem_addr_i,
  input  logic [7:0]      dmem_data_i,
  input  logic [RAW-1:0]  probe_reg_i,
  input  logic [DAW-1:0]  probe_addr_i,
  output logic [XLEN-1:0] reg_val_o,
  output logic [XLEN-1:0] mem_val_o,
  output logic [XLEN-1:0] pc_o,
  output logic            err_o
);
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] pc_q;
  logic            err_q;
  logic [31:0]     instr;

  logic [RAW-1:0]  rs, rt, rd, ra_sel, waddr;
  logic [XLEN-1:0] imm, op_a, op_b, rf_b, alu, ld_data, wdata;
  ctrl_t           ctrl;
  logic            is_mem, misal, rf_we, dm_we;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_data_i;
  end

  assign instr = imem[pc_q[IAW+1:2]];

  rsub_decode u_dec (
    .instr_i (instr),
    .rs_o    (rs),
    .rt_o    (rt),
    .rd_o    (rd),
    .imm_o   (imm),
    .ctrl_o  (ctrl)
  );

  // read port A doubles as the probe while halted
  assign ra_sel = run_i ? rs : probe_reg_i;

  rsub_regfile #(.NREG(1 << RAW), .DW(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_i      (ra_sel),
    .rb_i      (rt),
    .rdata_a_o (op_a),
    .rdata_b_o (rf_b),
    .we_i      (rf_we),
    .waddr_i   (waddr),
    .wdata_i   (wdata)
  );

  assign op_b = ctrl.use_imm ? imm : rf_b;
  assign alu  = ctrl.sub ? (op_a - op_b) : (op_a + op_b);

  assign is_mem = ctrl.mem_rd | ctrl.mem_wr;
  assign misal  = is_mem & (alu[1:0] != 2'b00);

  assign rf_we = run_i & ctrl.reg_we & ~misal;
  assign dm_we = run_i & ctrl.mem_wr & ~misal;
  assign waddr = ctrl.dst_rd ? rd : rt;
  assign wdata = ctrl.mem_rd ? ld_data : alu;

  rsub_dmem #(.NBYTES(DMEM_BYTES)) u_dmem (
    .clk_i     (clk_i),
    .wr_en_i   (dm_we),
    .wr_idx_i  (alu[DAW-1:2]),
    .wr_data_i (rf_b),
    .ld_en_i   (dmem_we_i & ~run_i),
    .ld_addr_i (dmem_addr_i),
    .ld_byte_i (dmem_data_i),
    .rd_idx_i  (alu[DAW-1:2]),
    .rd_data_o (ld_data),
    .pr_idx_i  (probe_addr_i[DAW-1:2]),
    .pr_data_o (mem_val_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else if (run_i) begin
      pc_q <= pc_q + XLEN'(4);
      if (misal) err_q <= 1'b1;
    end
  end

  assign pc_o      = pc_q;
  assign err_o     = err_q;
  assign reg_val_o = op_a;

  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (pc_o == $past(pc_o) + XLEN'(4)));
  p_pc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_o));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_err_raise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && misal) |=> err_o);
  p_misal_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misal |-> (!rf_we && !dm_we));
  p_halt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!rf_we && !dm_we));
endmodule

// File: tb/sim_rsub_core.sv
module sim_rsub_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        iwe = 1'b0;
  logic [5:0]  iaddr = '0;
  logic [31:0] idata = '0;
  logic        dwe = 1'b0;
  logic [7:0]  daddr = '0;
  logic [7:0]  ddata = '0;
  logic [4:0]  psel = '0;
  logic [7:0]  paddr = '0;
  logic [31:0] reg_val, mem_val, pc;
  logic        err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rsub_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .imem_we_i(iwe), .imem_addr_i(iaddr), .imem_data_i(idata),
    .dmem_we_i(dwe), .dmem_addr_i(daddr), .dmem_data_i(ddata),
    .probe_reg_i(psel), .probe_addr_i(paddr),
    .reg_val_o(reg_val), .mem_val_o(mem_val), .pc_o(pc), .err_o(err)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    logic [31:0] v = imm;
    return {6'(op), 5'(rs), 5'(rt), v[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic put_instr(int idx, logic [31:0] w);
    @(negedge clk); iwe = 1'b1; iaddr = 6'(idx); idata = w;
    @(negedge clk); iwe = 1'b0;
  endtask

  task automatic put_word(int addr, logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); dwe = 1'b1; daddr = 8'(addr + b); ddata = w[31-8*b -: 8];
    end
    @(negedge clk); dwe = 1'b0;
  endtask

  task automatic reg_is(string req, int r, logic [31:0] exp);
    @(negedge clk); psel = 5'(r); #1;
    chk(req, reg_val, exp);
  endtask

  task automatic mem_is(string req, int a, logic [31:0] exp);
    @(negedge clk); paddr = 8'(a); #1;
    chk(req, mem_val, exp);
  endtask

  task automatic run_for(int n);
    @(negedge clk); run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                      32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF,
                                      32'h0000_FFFF};

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1; chk("R1 pc", pc, 32'd0); chk("R1 err", {31'd0, err}, 32'd0);
    reg_is("R1 reg", 17, 32'd0);
    // R2 encoding of add r8,r17,r18
    chk("R2 encoding", enc_r(17, 18, 8, 0, 32), 32'h0232_4020);

    put_instr(0,  enc_i(8, 0, 9, 40));
    put_instr(1,  enc_i(35, 9, 17, -40));
    put_instr(2,  enc_i(35, 9, 18, -36));
    put_instr(3,  enc_r(17, 18, 8, 0, 32));
    put_instr(4,  enc_r(17, 18, 4, 0, 34));
    put_instr(5,  enc_i(43, 9, 8, -32));
    put_instr(6,  enc_i(43, 9, 4, -28));
    put_instr(8,  enc_r(17, 18, 0, 0, 32));
    put_instr(9,  enc_i(35, 9, 6, -39));
    put_instr(10, enc_i(43, 9, 8, -26));
    put_instr(11, enc_i(63, 17, 10, 5));
    put_instr(12, enc_r(17, 18, 11, 0, 33));
    put_instr(13, enc_r(17, 18, 12, 1, 32));
    for (int k = 14; k < 20; k++) put_instr(k, 32'd0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b, imm;
        a = VALS[i]; b = VALS[j];
        imm = {{16{b[15]}}, b[15:0]};
        do_reset();
        put_instr(7, enc_i(8, 17, 5, int'(b[15:0])));
        put_word(0, a);
        put_word(4, b);
        mem_is("R10 probe word", 0, a);
        run_for(9);
        chk("R7 err clear before misalign", {31'd0, err}, 32'd0);
        @(negedge clk); run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        chk("R7 err set", {31'd0, err}, 32'd1);
        chk("R9 pc after 14", pc, 32'd56);
        reg_is("R4 load big-endian", 17, a);
        reg_is("R4 load neg offset", 18, b);
        reg_is("R3 addi base", 9, 32'd40);
        reg_is("R2 add", 8, a + b);
        reg_is("R2 sub", 4, a - b);
        reg_is("R3 addi sext", 5, a + imm);
        reg_is("R6 r0 zero", 0, 32'd0);
        reg_is("R7 misaligned load", 6, 32'd0);
        reg_is("R8 bad opcode", 10, 32'd0);
        reg_is("R8 bad funct", 11, 32'd0);
        reg_is("R8 nonzero shamt", 12, 32'd0);
        mem_is("R5 store sum", 8, a + b);
        mem_is("R7 misaligned store", 12, a - b);
        repeat (3) @(negedge clk);
        chk("R9 pc hold", pc, 32'd56);
        chk("R7 err sticky", {31'd0, err}, 32'd1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule